// File: doc/BRIEF.md
# I2C Single-Master Byte Engine

This block is a bus master for a two-wire serial bus with one master. Software talks to it through a byte-wide data write port, a read strobe and a few control levels. When master operation is enabled, a byte written while the engine is idle produces a START condition and then sends that byte. The byte carries the target address in its upper seven bits and the transfer direction in bit 0. Later writes during a write transfer are buffered one deep and sent back to back. When no byte is waiting, the engine parks the bus with SCL held low.

In a read transfer the engine keeps clocking in bytes without further prompting. After each byte it raises a data-available flag. It ends the stream only when software has armed a stop request. The request is deferred, so the byte whose acknowledge phase comes next is the last one and is followed by STOP. The acknowledge level after each received byte comes from the engine by default. In manual mode it comes from a software-supplied level instead.

Both bus lines are driven as open-drain enables, where 1 pulls the line low. They are timed from a fixed clock divider, and every bit lasts four quarter periods. There is no arbitration and no detection of clock stretching.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, and whenever the engine is idle, scl_oe_o and sda_oe_o are 0, busy_o is 0, tx_empty_o is 1, rx_avail_o is 0 and nack_o is 0 (the last two until a transfer sets them).
- R2: A wr_i pulse while idle with master_en_i=1 produces a START (SDA falls while SCL is high) and then sends wdata_i MSB first. A wr_i pulse while master_en_i=0 is ignored and the bus stays released.
- R3: Each bit takes 4*CLK_DIV clocks, with SCL low for the first half and released for the second half. The master changes SDA only while SCL is low, except for the START and STOP edges.
- R4: Bit 0 of the first byte selects the direction: 0 means the master writes the following bytes, and 1 means it reads them.
- R5: In a write transfer, after a slave ACK (SDA low at the ninth clock), a buffered byte is sent next. Otherwise SCL is held low until a byte is written or a stop is requested. tx_empty_o is 1 whenever the one-byte buffer is free.
- R6: A slave NACK (SDA high at the ninth clock) after a sent byte sets nack_o. The engine then holds SCL low and sends no further byte, even if one is written, until a stop is requested. nack_o clears at the next START.
- R7: In a write transfer, a stop_req_i pulse produces a STOP (SDA rises while SCL is high) once the current byte and any buffered byte are done. busy_o then returns to 0.
- R8: In a read transfer, bytes are received one after another without software action. Each completed byte appears on rdata_o with rx_avail_o=1, and a rd_i pulse clears rx_avail_o.
- R9: With man_ack_en_i=0, the master drives ACK (SDA low) after every received byte except the one followed by STOP, which gets NACK (SDA released).
- R10: In a read transfer, a stop request applies to the first received byte whose acknowledge phase has not yet begun. That byte is the last one and is followed by STOP.
- R11: With man_ack_en_i=1, the acknowledge level after each received byte is man_ack_lvl_i as sampled at the start of that acknowledge phase (1 = NACK, 0 = ACK). Reception continues after a NACK unless a stop was requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_en_i | input | 1 | Enables master operation |
| wr_i | input | 1 | Data write strobe, one cycle |
| wdata_i | input | 8 | Byte to send; bit 0 of the first byte is the direction |
| rd_i | input | 1 | Data read strobe, clears rx_avail_o |
| stop_req_i | input | 1 | Arms a deferred STOP, one-cycle pulse |
| man_ack_en_i | input | 1 | Selects the software acknowledge level |
| man_ack_lvl_i | input | 1 | Acknowledge level in manual mode (1 = NACK) |
| sda_i | input | 1 | SDA line level |
| rdata_o | output | 8 | Last received byte |
| rx_avail_o | output | 1 | A received byte is waiting |
| tx_empty_o | output | 1 | Transmit buffer free |
| nack_o | output | 1 | Slave refused the last sent byte |
| busy_o | output | 1 | A transfer is in progress |
| scl_oe_o | output | 1 | Pull SCL low |
| sda_oe_o | output | 1 | Pull SDA low |

## Verification
The bench builds the engine with CLK_DIV=3 and SYNC_STAGES=2. A bit therefore lasts only 12 clocks, so write streams, an address NACK, and automatic and manual read streams of several bytes all fit in a short run. This setting also gives the smallest margin between the slave's drive at the falling SCL edge and the master's synchronised sample at the end of the high phase. A slave model on the wired-AND bus decodes START, bytes, acknowledge bits and STOP. It feeds them to a scoreboard that also checks the SCL bit period, so both the deferred-stop placement and the acknowledge level of every received byte are compared at the pins.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_TXBIT, ST_TXACK,
    ST_RXBIT, ST_RXACK, ST_HOLD, ST_STOP
  } i2cm_state_e;
endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
  parameter int CLK_DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!en_i)         cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/i2cm_shreg.sv
module i2cm_shreg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] din_i,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (load_i)  q_o <= din_i;
    else if (shift_i) q_o <= {q_o[W-2:0], bit_i};
  end
endmodule

// File: rtl/i2cm_pins.sv
module i2cm_pins
  import i2cm_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  i2cm_state_e st_i,
  input  logic [1:0]  q_i,
  input  logic        tx_bit_i,
  input  logic        ack_nack_i,
  output logic        scl_oe_o,
  output logic        sda_oe_o
);
  logic scl_n, sda_n, upd;

  always_comb begin
    scl_n = 1'b0;
    sda_n = 1'b0;
    unique case (st_i)
      ST_START: sda_n = q_i[1];
      ST_TXBIT: begin scl_n = !q_i[1]; sda_n = !tx_bit_i;   end
      ST_TXACK: scl_n = !q_i[1];
      ST_RXBIT: scl_n = !q_i[1];
      ST_RXACK: begin scl_n = !q_i[1]; sda_n = !ack_nack_i; end
      ST_HOLD:  begin scl_n = 1'b1;    sda_n = 1'b1;        end
      ST_STOP:  begin scl_n = !q_i[1]; sda_n = (q_i != 2'd3); end
      default:  ;
    endcase
  end

  // data SDA moves one cycle after SCL is already low
  assign upd = (scl_oe_o && scl_n) || (st_i == ST_IDLE) || (st_i == ST_START) ||
               (st_i == ST_STOP && q_i[1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_oe_o <= 1'b0;
      sda_oe_o <= 1'b0;
    end else begin
      scl_oe_o <= scl_n;
      if (upd) sda_oe_o <= sda_n;
    end
  end
endmodule

// File: rtl/i2cm_fsm.sv
module i2cm_fsm
  import i2cm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_en_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              rd_i,
  input  logic              stop_req_i,
  input  logic              man_ack_en_i,
  input  logic              man_ack_lvl_i,
  input  logic              sda_s_i,
  input  logic              tick_i,
  input  logic [BYTE_W-1:0] sr_i,
  output i2cm_state_e       st_o,
  output logic [1:0]        q_o,
  output logic              tick_en_o,
  output logic              load_o,
  output logic [BYTE_W-1:0] ld_data_o,
  output logic              shift_o,
  output logic              ack_nack_o,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              rx_avail_o,
  output logic              tx_empty_o,
  output logic              nack_o,
  output logic              busy_o
);
  localparam int BCW = $clog2(BYTE_W);
  localparam logic [BCW-1:0] BLAST = BCW'(BYTE_W - 1);

  logic [BCW-1:0]    bitc_q;
  logic [BYTE_W-1:0] tx_buf_q;
  logic tx_full_q, rd_mode_q, stop_pend_q, end_after_q;
  logic last, start_req;

  assign last      = tick_i && (q_o == 2'd3);
  assign start_req = wr_i && master_en_i;
  assign load_o    = (st_o == ST_START && last) ||
                     (st_o == ST_TXACK && last && !sda_s_i && !rd_mode_q && tx_full_q) ||
                     (st_o == ST_HOLD && !nack_o && tx_full_q);
  assign ld_data_o = tx_buf_q;
  assign shift_o   = last && (st_o == ST_TXBIT || st_o == ST_RXBIT);
  assign tick_en_o = (st_o != ST_IDLE) && (st_o != ST_HOLD);
  assign tx_empty_o = !tx_full_q;
  assign busy_o    = (st_o != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_o <= ST_IDLE;       q_o <= '0;          bitc_q <= '0;
      tx_buf_q <= '0;        tx_full_q <= 1'b0;  rd_mode_q <= 1'b0;
      stop_pend_q <= 1'b0;   end_after_q <= 1'b0; ack_nack_o <= 1'b0;
      rdata_o <= '0;         rx_avail_o <= 1'b0; nack_o <= 1'b0;
    end else begin
      if (rd_i) rx_avail_o <= 1'b0;
      if (tick_i) q_o <= q_o + 2'd1;
      if (st_o != ST_IDLE) begin
        if (start_req) begin tx_buf_q <= wdata_i; tx_full_q <= 1'b1; end
        if (stop_req_i) stop_pend_q <= 1'b1;
      end
      if (load_o) begin tx_full_q <= 1'b0; bitc_q <= '0; end
      unique case (st_o)
        ST_IDLE: begin
          q_o <= '0; stop_pend_q <= 1'b0; tx_full_q <= 1'b0;
          if (start_req) begin
            st_o <= ST_START; tx_buf_q <= wdata_i; tx_full_q <= 1'b1;
            rd_mode_q <= wdata_i[0]; nack_o <= 1'b0; rx_avail_o <= 1'b0;
          end
        end
        ST_START: if (last) st_o <= ST_TXBIT;
        ST_TXBIT: if (last) begin
          if (bitc_q == BLAST) st_o <= ST_TXACK;
          else                 bitc_q <= bitc_q + 1'b1;
        end
        ST_TXACK: if (last) begin
          if (sda_s_i) begin nack_o <= 1'b1; st_o <= ST_HOLD; end
          else if (rd_mode_q) begin st_o <= ST_RXBIT; bitc_q <= '0; end
          else if (tx_full_q) st_o <= ST_TXBIT;
          else if (stop_pend_q) st_o <= ST_STOP;
          else st_o <= ST_HOLD;
        end
        ST_HOLD: begin
          q_o <= '0;
          if (load_o) st_o <= ST_TXBIT;
          else if (stop_pend_q) st_o <= ST_STOP;
        end
        ST_RXBIT: if (last) begin
          if (bitc_q == BLAST) begin
            st_o <= ST_RXACK;
            rdata_o <= {sr_i[BYTE_W-2:0], sda_s_i};
            rx_avail_o <= 1'b1;
            ack_nack_o <= man_ack_en_i ? man_ack_lvl_i : stop_pend_q;
            end_after_q <= stop_pend_q;
            stop_pend_q <= 1'b0;
          end else bitc_q <= bitc_q + 1'b1;
        end
        ST_RXACK: if (last) begin
          if (end_after_q) st_o <= ST_STOP;
          else begin st_o <= ST_RXBIT; bitc_q <= '0; end
        end
        ST_STOP: if (last) st_o <= ST_IDLE;
        default: st_o <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2cm_pkg::*;
#(
  parameter int CLK_DIV     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_en_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              rd_i,
  input  logic              stop_req_i,
  input  logic              man_ack_en_i,
  input  logic              man_ack_lvl_i,
  input  logic              sda_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              rx_avail_o,
  output logic              tx_empty_o,
  output logic              nack_o,
  output logic              busy_o,
  output logic              scl_oe_o,
  output logic              sda_oe_o
);
  logic [SYNC_STAGES-1:0] sda_sync_q;
  logic [BYTE_W-1:0]      sr, ld_data;
  logic [1:0]             q;
  i2cm_state_e            st;
  logic tick, tick_en, load, shift, ack_nack, sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sda_sync_q <= '1;
    else         sda_sync_q <= {sda_sync_q[SYNC_STAGES-2:0], sda_i};
  end
  assign sda_s = sda_sync_q[SYNC_STAGES-1];

  i2cm_tick #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk_i, .rst_ni, .en_i(tick_en), .tick_o(tick)
  );

  i2cm_shreg #(.W(BYTE_W)) u_shreg (
    .clk_i, .rst_ni, .load_i(load), .din_i(ld_data),
    .shift_i(shift), .bit_i(sda_s), .q_o(sr)
  );

  i2cm_fsm u_fsm (
    .clk_i, .rst_ni, .master_en_i, .wr_i, .wdata_i, .rd_i, .stop_req_i,
    .man_ack_en_i, .man_ack_lvl_i, .sda_s_i(sda_s), .tick_i(tick), .sr_i(sr),
    .st_o(st), .q_o(q), .tick_en_o(tick_en), .load_o(load), .ld_data_o(ld_data),
    .shift_o(shift), .ack_nack_o(ack_nack), .rdata_o, .rx_avail_o, .tx_empty_o,
    .nack_o, .busy_o
  );

  i2cm_pins u_pins (
    .clk_i, .rst_ni, .st_i(st), .q_i(q), .tx_bit_i(sr[BYTE_W-1]),
    .ack_nack_i(ack_nack), .scl_oe_o, .sda_oe_o
  );
endmodule

// File: rtl/i2cm_chk.sv
module i2cm_chk
  import i2cm_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input i2cm_state_e st_i,
  input logic        man_ack_en_i,
  input logic        scl_oe_i,
  input logic        sda_oe_i,
  input logic        busy_i,
  input logic        nack_i,
  input logic        rx_avail_i
);
  AST_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (!scl_oe_i && !sda_oe_i)); // R1

  AST_SDA_ONLY_COND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scl_oe_i && !$past(scl_oe_i) && (sda_oe_i != $past(sda_oe_i))) |->
      (sda_oe_i ? (st_i == ST_START) : (st_i == ST_STOP))); // R3

  AST_HOLD_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_HOLD && $past(st_i) == ST_HOLD) |-> scl_oe_i); // R5

  AST_NACK_PARKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nack_i |-> (st_i == ST_HOLD || st_i == ST_STOP || st_i == ST_IDLE)); // R6

  AST_RX_AVAIL_AT_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_avail_i) |-> (st_i == ST_RXACK)); // R8

  AST_AUTO_NACK_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_STOP && $past(st_i) == ST_RXACK && !man_ack_en_i) |-> !sda_oe_i); // R9
endmodule

bind i2c_byte_master i2cm_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .st_i(st), .man_ack_en_i(man_ack_en_i),
  .scl_oe_i(scl_oe_o), .sda_oe_i(sda_oe_o), .busy_i(busy_o),
  .nack_i(nack_o), .rx_avail_i(rx_avail_o)
);

// File: tb/i2c_byte_master_bench.sv
module i2c_byte_master_bench;
  localparam int CLK_DIV = 3;
  localparam int EV_START = 1000;
  localparam int EV_STOP  = 1001;
  localparam logic [6:0] SLV = 7'h50;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic master_en = 1'b1, wr = 1'b0, rd = 1'b0, stop_req = 1'b0;
  logic man_en = 1'b0, man_lvl = 1'b0, s_drv = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic rx_avail, tx_empty, nack, busy, scl_oe, sda_oe, sda_line;

  assign sda_line = !(sda_oe || s_drv);
  always #4 clk = !clk;

  i2c_byte_master #(.CLK_DIV(CLK_DIV), .SYNC_STAGES(2)) u_i2c_byte_master (
    .clk_i(clk), .rst_ni, .master_en_i(master_en), .wr_i(wr), .wdata_i(wdata),
    .rd_i(rd), .stop_req_i(stop_req), .man_ack_en_i(man_en), .man_ack_lvl_i(man_lvl),
    .sda_i(sda_line), .rdata_o(rdata), .rx_avail_o(rx_avail), .tx_empty_o(tx_empty),
    .nack_o(nack), .busy_o(busy), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe)
  );

  typedef struct { int ev; string tag; } exp_t;
  exp_t exp_q[$];
  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_ev(input int ev, input string tag);
    exp_t e;
    e.ev = ev; e.tag = tag;
    exp_q.push_back(e);
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'hA5 ^ 8'(i * 59);
  endfunction

  // slave model and scoreboard monitor
  logic scl_p = 1'b1, sda_p = 1'b1, is_read = 1'b0, hit = 1'b0, s_done = 1'b0;
  int bitn = 0, bidx = 0, t_rise = 0;
  logic [7:0] mbyte = '0;

  task automatic observe(input int ev);
    exp_t e;
    if (exp_q.size() == 0) chk(1'b0, "unexpected bus event", ev, -1);
    else begin
      e = exp_q.pop_front();
      chk(ev == e.ev, e.tag, ev, e.ev);
    end
  endtask

  always @(negedge clk) begin
    logic scl_n, sda_n;
    cyc++;
    scl_n = !scl_oe;
    sda_n = sda_line;
    if (rst_ni) begin
      if (scl_n && scl_p && sda_p && !sda_n) begin
        bitn = 0; bidx = 0; is_read = 0; hit = 0; s_done = 0;
        observe(EV_START);
      end else if (scl_n && scl_p && !sda_p && sda_n) begin
        s_drv = 1'b0;
        observe(EV_STOP);
      end else if (scl_n && !scl_p) begin
        if (bitn == 1) chk(cyc - t_rise == 4 * CLK_DIV, "R3 bit period", cyc - t_rise, 4 * CLK_DIV);
        t_rise = cyc;
        if (bitn < 8) mbyte = {mbyte[6:0], sda_n};
        bitn++;
        if (bitn == 8 && bidx == 0) begin
          hit = (mbyte[7:1] == SLV);
          is_read = mbyte[0];
        end
        if (bitn == 9) begin
          observe({23'd0, sda_n, mbyte});
          if (is_read && bidx > 0 && sda_n) s_done = 1'b1;
          bidx++;
          bitn = 0;
        end
      end else if (!scl_n && scl_p) begin
        if (bidx == 0 || !is_read) s_drv = (bitn == 8) && hit;
        else if (s_done || bitn == 8) s_drv = 1'b0;
        else s_drv = !pat(bidx - 1)[7 - bitn];
      end
    end
    scl_p = scl_n;
    sda_p = sda_n;
  end

  task automatic wr_byte(input logic [7:0] b);
    @(negedge clk); wr = 1'b1; wdata = b;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop_req = 1'b1;
    @(negedge clk); stop_req = 1'b0;
  endtask

  task automatic pulse_rd();
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic wait_tx_empty();
    while (!tx_empty) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_rx();
    while (!rx_avail) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!scl_oe && !sda_oe, "R1 bus released in reset", {scl_oe, sda_oe}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && tx_empty, "R1 idle flags", {busy, tx_empty}, 1);
    chk(!rx_avail && !nack, "R1 status clear", {rx_avail, nack}, 0);

    // write transfer, address 0x50, two data bytes, park, stop
    expect_ev(EV_START, "R2 start");
    expect_ev({23'd0, 1'b0, 8'hA0}, "R2 R4 address write");
    expect_ev({23'd0, 1'b0, 8'h3C}, "R5 first data byte");
    expect_ev({23'd0, 1'b0, 8'hC3}, "R5 buffered data byte");
    expect_ev(EV_STOP, "R7 stop after write");
    wr_byte(8'hA0);
    wait_tx_empty();
    wr_byte(8'h3C);
    chk(!tx_empty, "R5 buffer occupied", tx_empty, 0);
    wait_tx_empty();
    wr_byte(8'hC3);
    wait_tx_empty();
    repeat (150) @(negedge clk);
    chk(busy && scl_oe && tx_empty, "R5 parked with SCL low", {busy, scl_oe, tx_empty}, 7);
    pulse_stop();
    wait_idle();
    chk(!busy && !scl_oe && !sda_oe, "R7 idle after stop", {busy, scl_oe, sda_oe}, 0);

    // master disabled: write ignored
    master_en = 1'b0;
    wr_byte(8'hA0);
    repeat (40) @(negedge clk);
    chk(!busy && !scl_oe && !sda_oe, "R2 write ignored when disabled", {busy, scl_oe, sda_oe}, 0);
    master_en = 1'b1;

    // address NACK
    expect_ev(EV_START, "R2 start");
    expect_ev({23'd0, 1'b1, 8'h44}, "R6 address refused");
    wr_byte(8'h44);
    while (!nack && busy) @(negedge clk);
    chk(nack, "R6 nack flag", nack, 1);
    wr_byte(8'h12);
    repeat (100) @(negedge clk);
    chk(busy && scl_oe, "R6 parked after nack", {busy, scl_oe}, 3);
    expect_ev(EV_STOP, "R6 stop after nack");
    pulse_stop();
    wait_idle();

    // automatic-ack read of three bytes
    expect_ev(EV_START, "R2 start");
    expect_ev({23'd0, 1'b0, 8'hA1}, "R4 address read");
    expect_ev({23'd0, 1'b0, pat(0)}, "R9 ack byte 0");
    expect_ev({23'd0, 1'b0, pat(1)}, "R9 ack byte 1");
    expect_ev({23'd0, 1'b1, pat(2)}, "R9 R10 nack on last byte");
    expect_ev(EV_STOP, "R10 stop after last byte");
    wr_byte(8'hA1);
    for (int i = 0; i < 3; i++) begin
      wait_rx();
      chk(rdata == pat(i), "R4 R8 received data", rdata, pat(i));
      pulse_rd();
      chk(!rx_avail, "R8 read clears flag", rx_avail, 0);
      if (i == 1) pulse_stop();
    end
    wait_idle();

    // manual-ack read: ACK, NACK without stop, then stop
    man_en = 1'b1;
    man_lvl = 1'b0;
    expect_ev(EV_START, "R2 start");
    expect_ev({23'd0, 1'b0, 8'hA1}, "R4 address read");
    expect_ev({23'd0, 1'b0, pat(0)}, "R11 manual ack");
    expect_ev({23'd0, 1'b1, pat(1)}, "R11 manual nack");
    expect_ev({23'd0, 1'b1, 8'hFF}, "R11 stream continues after nack");
    expect_ev(EV_STOP, "R10 stop in manual mode");
    wr_byte(8'hA1);
    for (int i = 0; i < 3; i++) begin
      wait_rx();
      chk(rdata == ((i == 2) ? 8'hFF : pat(i)), "R8 R11 received data", rdata,
          (i == 2) ? 8'hFF : pat(i));
      pulse_rd();
      if (i == 0) man_lvl = 1'b1;
      if (i == 1) pulse_stop();
    end
    wait_idle();
    man_en = 1'b0;

    chk(exp_q.size() == 0, "R7 all expected bus events seen", exp_q.size(), 0);
    summary();
  end
endmodule